// File: doc/BRIEF.md
# DRAM Array Model with Compressed Parallel Test Mode

This block is a synthesizable, clock-sampled model of a small dynamic memory that is four bits wide. It watches active-low row and column strobes, a write strobe and an output enable, takes a multiplexed row/column address, and shares one bidirectional 4-bit data bus. In normal mode every column access reads or writes one 4-bit word. The two lowest column bits choose one of the four cells that sit behind each data pin.

A special strobe ordering switches the array into a compressed test organization. In this mode each data pin covers a group of four cells. A write copies the bit on each pin into all four cells of its group, and the two low column bits are ignored. A read does not return stored data. Instead, each pin reports whether its four cells hold the same value. A plain refresh ordering with the write strobe high ends the mode, and so does a row cycle that carries no column access.

All strobe edges are found by comparing each input with its value at the previous clock. The cycle type is decided once, on the clock where the row strobe is seen to fall. Row and column widths are parameters, and the column width must be at least 3.

Top module: `tmc_dram_model`

## Requirements
- R1: When the row strobe falls while both the column strobe and the write strobe are already low, `in_test` is 1 from the next clock on.
- R2: When the row strobe falls while the column strobe is low and the write strobe is high, `in_test` is 0 from the next clock on, whatever mode was active before.
- R3: A row cycle opened with the column strobe high that ends with no column strobe fall clears `in_test` at the row strobe rise. A row cycle that contains a column access leaves the mode unchanged.
- R4: In normal mode, a column strobe fall with the write strobe low during a row cycle stores `dq` into the word at {row, column}.
- R5: In normal mode, from the clock after a column strobe fall with the write strobe high, `dq` carries the word at {row, column} while the output enable is low.
- R6: In test mode, a write stores the 4-bit `dq` value into all four words whose column differs only in bits [1:0]. Column bits [1:0] have no effect.
- R7: In test mode, a read drives `dq[p]` = 1 when bit p is equal in all four words of the addressed group and 0 otherwise. Column bits [1:0] have no effect.
- R8: `dq` is driven only from the clock after a read column strobe fall, while the column strobe stays low and the output enable is low. At all other times it is high-impedance.
- R9: After reset `in_test` is 0. It changes only on a clock where a row strobe edge is seen. A second entry ordering while in test mode keeps it at 1.
- R10: Reset clears every cell to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W, COL_W) | Multiplexed row/column address |
| dq | inout | 4 | Bidirectional data bus |
| in_test | output | 1 | High while the compressed test organization is active |

## Verification
The row strobe edge serves two jobs. It chooses between a column-access cycle and a refresh ordering, and in the same clock it may change the mode. The bench drops the column strobe one clock before the row strobe, with the write strobe at both levels, and checks two things: the mode flag flips as intended, and later reads show that no cell changed. A second overlap comes at the row strobe rise. There the exit decision depends on whether a column access happened inside the same cycle. The bench closes row cycles with and without column activity while in test mode, and compares the mode flag on every clock against its own model.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int DQ_W  = 4;
  localparam int GRP   = 4;
  localparam int GRP_W = 2;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_ROW  = 2'd1,
    CYC_CBR  = 2'd2,
    CYC_WCBR = 2'd3
  } cyc_e;

  // Strobe ordering seen at the row strobe fall.
  function automatic cyc_e classify(input logic cas_n, input logic we_n);
    if (cas_n)     return CYC_ROW;
    else if (we_n) return CYC_CBR;
    else           return CYC_WCBR;
  endfunction

  // Per-pin equality over the four cells of one group.
  function automatic logic [DQ_W-1:0] lane_match(input logic [DQ_W-1:0] c0,
                                                 input logic [DQ_W-1:0] c1,
                                                 input logic [DQ_W-1:0] c2,
                                                 input logic [DQ_W-1:0] c3);
    logic [DQ_W-1:0] f;
    for (int p = 0; p < DQ_W; p++)
      f[p] = (c0[p] == c1[p]) && (c1[p] == c2[p]) && (c2[p] == c3[p]);
    return f;
  endfunction
endpackage

// File: rtl/tmc_strobe_dec.sv
module tmc_strobe_dec
  import tmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic ras_fall,
  output cyc_e cyc,
  output logic col_open,
  output logic col_read,
  output logic acc_go,
  output logic wr_go,
  output logic test_mode
);
  logic ras_q, cas_q, saw_cas;
  logic ras_rise, cas_fall, cas_rise;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;

  // A column access exists only inside a row cycle still held open.
  assign acc_go = cas_fall && (cyc == CYC_ROW) && !ras_n;
  assign wr_go  = acc_go && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      cyc       <= CYC_IDLE;
      saw_cas   <= 1'b0;
      col_open  <= 1'b0;
      col_read  <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;

      if (ras_fall) begin
        cyc     <= classify(cas_n, we_n);
        saw_cas <= 1'b0;
      end else if (ras_rise) begin
        cyc <= CYC_IDLE;
      end

      if (acc_go) begin
        saw_cas  <= 1'b1;
        col_open <= 1'b1;
        col_read <= we_n;
      end else if (cas_rise || ras_rise) begin
        col_open <= 1'b0;
      end

      // Mode moves only on row strobe edges.
      if (ras_fall) begin
        if (!cas_n) test_mode <= !we_n;
      end else if (ras_rise && (cyc == CYC_ROW) && !saw_cas) begin
        test_mode <= 1'b0;
      end
    end
  end

  a_r1_wcbr_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> test_mode);
  a_r2_cbr_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);
  a_r3_access_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && saw_cas) |=> $stable(test_mode));
  a_r9_mode_only_on_ras_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_fall && !ras_rise) |=> $stable(test_mode));
endmodule

// File: rtl/tmc_cell_array.sv
module tmc_cell_array
  import tmc_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_we,
  input  logic [ROW_W-1:0] row_in,
  input  logic             acc_go,
  input  logic             wr_go,
  input  logic [COL_W-1:0] col_in,
  input  logic             test_mode,
  input  logic [DQ_W-1:0]  wdata,
  output logic [DQ_W-1:0]  rdata
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int WORDS = 1 << IDX_W;

  logic [DQ_W-1:0]  mem [WORDS];
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  // Word index of one lane inside the group picked by the upper column bits.
  function automatic logic [IDX_W-1:0] cell_at(input logic [ROW_W-1:0] r,
                                               input logic [COL_W-1:0] c,
                                               input logic [GRP_W-1:0] lane);
    return {r, c[COL_W-1:GRP_W], lane};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (row_we) row_q <= row_in;
      if (acc_go) col_q <= col_in;
      if (wr_go) begin
        if (test_mode) begin
          for (int k = 0; k < GRP; k++)
            mem[cell_at(row_q, col_in, k[GRP_W-1:0])] <= wdata;
        end else begin
          mem[cell_at(row_q, col_in, col_in[GRP_W-1:0])] <= wdata;
        end
      end
    end
  end

  always_comb begin
    if (test_mode)
      rdata = lane_match(mem[cell_at(row_q, col_q, 2'd0)],
                         mem[cell_at(row_q, col_q, 2'd1)],
                         mem[cell_at(row_q, col_q, 2'd2)],
                         mem[cell_at(row_q, col_q, 2'd3)]);
    else
      rdata = mem[cell_at(row_q, col_q, col_q[GRP_W-1:0])];
  end

  a_r4_word_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !test_mode) |=> (rdata == $past(wdata)));
  a_r6_group_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && test_mode) |=> (rdata == '1));
endmodule

// File: rtl/tmc_dram_model.sv
module tmc_dram_model
  import tmc_pkg::*;
#(
  parameter  int ROW_W = 4,
  parameter  int COL_W = 4,
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  inout  wire  [DQ_W-1:0] dq,
  output logic            in_test
);
  logic            ras_fall, col_open, col_read, acc_go, wr_go, test_mode;
  cyc_e            cyc;
  logic [DQ_W-1:0] rdata;
  logic            dq_drive;

  tmc_strobe_dec u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ras_fall  (ras_fall),
    .cyc       (cyc),
    .col_open  (col_open),
    .col_read  (col_read),
    .acc_go    (acc_go),
    .wr_go     (wr_go),
    .test_mode (test_mode)
  );

  tmc_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_we    (ras_fall),
    .row_in    (addr[ROW_W-1:0]),
    .acc_go    (acc_go),
    .wr_go     (wr_go),
    .col_in    (addr[COL_W-1:0]),
    .test_mode (test_mode),
    .wdata     (dq),
    .rdata     (rdata)
  );

  assign dq_drive = col_open && col_read && !oe_n;
  assign dq       = dq_drive ? rdata : 'z;
  assign in_test  = test_mode;

  a_r8_drive_in_row_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> (cyc == CYC_ROW));
endmodule

// File: tb/tmc_dram_model_test.sv
`timescale 1ns/1ps
module tmc_dram_model_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0;
  logic [3:0] tb_dq = '0;
  logic       tb_drv = 1'b0;
  wire  [3:0] dq;
  logic       in_test;

  assign dq = tb_drv ? tb_dq : 4'bz;

  tmc_dram_model uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq(dq), .in_test(in_test)
  );

  always #2 clk = ~clk;

  int         checks = 0, fails = 0;
  bit         done = 0;
  string      cur_req = "R9";
  logic [3:0] ref_mem [256];
  logic       exp_mode = 1'b0;
  logic       exp_valid = 1'b0;
  logic [3:0] exp_dq = '0;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", cur_req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_read(input int row, input int col);
    logic [3:0] f;
    int base = row * 16 + (col & 12);
    if (!exp_mode) return ref_mem[row * 16 + col];
    for (int p = 0; p < 4; p++) begin
      f[p] = 1'b1;
      for (int k = 1; k < 4; k++)
        if (ref_mem[base + k][p] != ref_mem[base][p]) f[p] = 1'b0;
    end
    return f;
  endfunction

  // One clock: check the state left by the previous edge, then apply inputs.
  task automatic tick(input logic r, input logic c, input logic w, input logic o,
                      input int a, input logic drv, input logic [3:0] d);
    @(negedge clk);
    chk({3'b0, in_test}, {3'b0, exp_mode});
    if (exp_valid) chk(dq, exp_dq);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    addr = a[3:0]; tb_drv = drv; tb_dq = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      tick(1, 1, 1, 1, 0, 0, 4'h0);
      exp_valid = 1'b0;
    end
  endtask

  task automatic do_write(input int row, input int col, input logic [3:0] d);
    tick(0, 1, 1, 1, row, 0, 4'h0);
    tick(0, 0, 0, 1, col, 1, d);
    if (exp_mode) begin
      for (int k = 0; k < 4; k++) ref_mem[row * 16 + (col & 12) + k] = d;
    end else begin
      ref_mem[row * 16 + col] = d;
    end
    tick(0, 1, 1, 1, col, 0, 4'h0);
    tick(1, 1, 1, 1, 0, 0, 4'h0);
  endtask

  task automatic do_read(input int row, input int col, input bit late_oe);
    tick(0, 1, 1, 1, row, 0, 4'h0);
    tick(0, 0, 1, late_oe, col, 0, 4'h0);
    exp_dq = model_read(row, col);
    exp_valid = !late_oe;
    tick(0, 0, 1, 0, col, 0, 4'h0);
    exp_valid = 1'b1;
    tick(0, 0, 1, 0, col, 0, 4'h0);
    tick(0, 1, 1, 1, col, 0, 4'h0);
    exp_valid = 1'b0;
    tick(1, 1, 1, 1, 0, 0, 4'h0);
  endtask

  // Column strobe low before the row strobe falls: refresh ordering.
  task automatic refresh_order(input logic w);
    tick(1, 0, w, 1, 0, 0, 4'h0);
    tick(0, 0, w, 1, 0, 0, 4'h0);
    exp_mode = !w;
    tick(1, 0, w, 1, 0, 0, 4'h0);
    tick(1, 1, 1, 1, 0, 0, 4'h0);
  endtask

  task automatic row_only(input int row);
    tick(0, 1, 1, 1, row, 0, 4'h0);
    tick(1, 1, 1, 1, 0, 0, 4'h0);
    exp_mode = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 4'h0;
    cur_req = "R9";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R10";
    do_read(7, 9, 0);

    cur_req = "R4";
    do_write(1, 3, 4'h9);
    do_write(1, 2, 4'h6);
    do_write(5, 0, 4'hF);
    cur_req = "R5";
    do_read(1, 3, 0);
    do_read(1, 2, 0);
    do_read(5, 0, 0);

    cur_req = "R2";
    refresh_order(1'b1);
    cur_req = "R1";
    refresh_order(1'b0);
    cur_req = "R9";
    refresh_order(1'b0);

    cur_req = "R6";
    do_write(2, 5, 4'hA);
    cur_req = "R7";
    do_read(2, 6, 0);
    cur_req = "R3";
    idle(2);

    cur_req = "R2";
    refresh_order(1'b1);
    cur_req = "R6";
    do_read(2, 4, 0);
    do_read(2, 7, 0);
    cur_req = "R4";
    do_write(2, 5, 4'h6);

    cur_req = "R1";
    refresh_order(1'b0);
    cur_req = "R7";
    do_read(2, 4, 0);
    do_read(2, 7, 0);
    do_read(1, 0, 0);

    cur_req = "R3";
    row_only(3);
    idle(2);
    cur_req = "R5";
    do_read(2, 5, 0);

    cur_req = "R8";
    do_read(1, 3, 1);
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule